// File: doc/BRIEF.md
# Link Power Status Supervisor

This block sits between a physical-layer core and its link layer and decides the state of the interface between them. It watches the link power status line driven by the link layer. A low interval on that line is measured in system clock cycles and sorted into one of three classes. A very short dip is ignored as noise. A medium dip means the link asked for a fresh start, so the block issues a single reset pulse to the interface. A long dip means the link has powered down, so the block shuts the interface off to save power.

While the interface is shut off, a link-on packet reported by the packet decoder starts a periodic wake-up clock. The link layer can use this clock to power itself back up. The wake-up clock keeps running, even after the link returns, until the link-control bit is seen set. When the power status line comes back high, the block enables the interface again.

Top module: `lps_supervisor`

## Requirements
- R1: After a synchronous active-low reset, `if_disabled` is 1, `if_enable` is 0, `if_reset` is 0 and `linkon_out` is 0.
- R2: `lps_in` passes through a two-flop synchronizer. From the disabled state, a high level driven before clock edge e0 gives `if_enable`=1 and `if_disabled`=0 after edge e2 (still disabled after e1), and no reset pulse is issued.
- R3: A low interval of `lps_in` lasting fewer than RST_THR cycles (default 59) is ignored: no `if_reset` pulse, and `if_enable` stays 1.
- R4: A low interval of at least RST_THR and fewer than OFF_THR cycles (default 1229) gives exactly one `if_reset` pulse, one cycle wide, issued after `lps_in` returns high. `if_enable` stays 1 throughout.
- R5: A low interval of OFF_THR cycles or more sets `if_disabled`=1 and `if_enable`=0, with no reset pulse. When `lps_in` returns high, the interface is enabled again.
- R6: A `linkon_pkt` strobe taken while disabled starts `linkon_out`, a clock of period LINKON_DIV cycles (default 8) with equal high and low times.
- R7: A `linkon_pkt` strobe taken while the interface is enabled is ignored, and `linkon_out` stays 0.
- R8: `lctrl_set` forces `linkon_out` to 0 from the next cycle and keeps it there. When it coincides with `linkon_pkt`, `lctrl_set` wins.
- R9: Once started, `linkon_out` keeps toggling after the interface has been re-enabled, until `lctrl_set` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominal 49.152 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| lps_in | input | 1 | Link power status from the link layer, high = link powered |
| linkon_pkt | input | 1 | One-cycle strobe: a link-on packet was received |
| lctrl_set | input | 1 | Link-control bit; when high, the wake-up clock is stopped |
| if_enable | output | 1 | Interface enabled |
| if_reset | output | 1 | One-cycle reset pulse to the interface |
| if_disabled | output | 1 | Interface shut off for power saving |
| linkon_out | output | 1 | Wake-up clock to the link layer, low when idle |

## Verification
The assertions assume that `linkon_pkt` and `lctrl_set` are synchronous to `clk`. Only `lps_in` may arrive asynchronously, and the checks are written against the synchronized copy of it. They also assume that `lctrl_set` is only a level to be sampled, so a clear in one cycle and a start strobe in the next are both legal. The stimulus drives every input on the falling edge. The low intervals are kept separated by settled high periods, so each one is measured from a counter that has been cleared. The interval lengths sit on both sides of each threshold.

// File: rtl/lps_sup_pkg.sv
// Package: shared types for the link power status supervisor.
// Assumes: nothing; holds only the controller state encoding.
package lps_sup_pkg;

    // Interface control states
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,   // interface shut off, waiting for link power
        ST_ON  = 2'd1,   // interface enabled, power status high
        ST_LOW = 2'd2    // interface enabled, measuring a low interval
    } sup_state_t;

endpackage

// File: rtl/lps_sync.sv
// Module: lps_sync
// Brings the asynchronous power status line into the clock domain with a
// chain of STAGES flops. Assumes STAGES >= 2; the reset value is "low"
// (link unpowered).
module lps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Purpose: shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/lps_low_timer.sv
// Module: lps_low_timer
// Counts consecutive cycles for which the synchronized power status is low.
// The count saturates at OFF_THR and clears on the first high cycle.
// Assumes: lps_s is already synchronous to clk.
module lps_low_timer #(
    parameter int OFF_THR = 1229,
    parameter int CW      = $clog2(OFF_THR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lps_s,
    output logic [CW-1:0] low_cnt
);
    localparam logic [CW-1:0] CNT_MAX = CW'(OFF_THR);

    // Purpose: saturating low-interval counter
    always_ff @(posedge clk) begin
        if (!rst_n)                    low_cnt <= '0;
        else if (lps_s)                low_cnt <= '0;
        else if (low_cnt != CNT_MAX)   low_cnt <= low_cnt + 1'b1;
    end
endmodule

// File: rtl/lps_ctrl_fsm.sv
// Module: lps_ctrl_fsm
// Decides the interface state from the synchronized power status and the
// length of the current low interval. Short dips are ignored, medium ones
// end in one reset pulse, long ones shut the interface off.
// Assumes: low_cnt counts edges with lps_s low and saturates at OFF_THR.
module lps_ctrl_fsm
    import lps_sup_pkg::*;
#(
    parameter int RST_THR = 59,
    parameter int OFF_THR = 1229,
    parameter int CW      = $clog2(OFF_THR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lps_s,
    input  logic [CW-1:0] low_cnt,
    output logic          if_enable,
    output logic          if_reset,
    output logic          if_disabled
);
    localparam logic [CW-1:0] RST_C = CW'(RST_THR);
    localparam logic [CW-1:0] OFF_C = CW'(OFF_THR);

    sup_state_t state, state_nxt;
    logic       pulse_nxt;

    // Purpose: next-state and reset-pulse decision
    always_comb begin
        state_nxt = state;
        pulse_nxt = 1'b0;
        case (state)
            ST_OFF: if (lps_s) state_nxt = ST_ON;
            ST_ON:  if (!lps_s) state_nxt = ST_LOW;
            ST_LOW: begin
                if (low_cnt >= OFF_C) begin
                    state_nxt = ST_OFF;
                end else if (lps_s) begin
                    state_nxt = ST_ON;
                    pulse_nxt = (low_cnt >= RST_C);
                end
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // Purpose: state and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            if_reset <= 1'b0;
        end else begin
            state    <= state_nxt;
            if_reset <= pulse_nxt;
        end
    end

    assign if_enable   = (state != ST_OFF);
    assign if_disabled = (state == ST_OFF);

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_reset |=> !if_reset);
    // R4
    pulse_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_reset |-> if_enable);
    // R3
    glitch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && lps_s && low_cnt < RST_C) |=> !if_reset);
    // R5
    off_needs_long_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_disabled) |-> ($past(low_cnt) >= OFF_C));
    // R2
    wake_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && lps_s) |=> (if_enable && !if_reset));
endmodule

// File: rtl/lps_linkon_gen.sv
// Module: lps_linkon_gen
// Produces the wake-up clock to the link layer. A link-on strobe seen while
// the interface is off starts it; the link-control bit stops it. The output
// is the top bit of a free-running divider, held low while idle.
// Assumes: DIV is a power of two, at least 2.
module lps_linkon_gen #(
    parameter int DIV = 8,
    parameter int DW  = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_off,
    input  logic linkon_pkt,
    input  logic lctrl_set,
    output logic linkon_out
);
    logic          active, active_nxt;
    logic [DW-1:0] div_cnt;

    // Purpose: start/stop decision, stop has priority
    always_comb begin
        active_nxt = active;
        if (lctrl_set)                  active_nxt = 1'b0;
        else if (linkon_pkt && link_off) active_nxt = 1'b1;
    end

    // Purpose: run flag and clock divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_cnt <= '0;
        end else begin
            active  <= active_nxt;
            div_cnt <= active_nxt ? div_cnt + 1'b1 : '0;
        end
    end

    assign linkon_out = div_cnt[DW-1];

    // R8
    linkon_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lctrl_set |=> !linkon_out);
    // R7
    linkon_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !link_off) |=> !linkon_out);
endmodule

// File: rtl/lps_supervisor.sv
// Module: lps_supervisor (top)
// Supervises the interface between the physical layer and the link layer
// from the link power status line, and drives the wake-up clock.
// Assumes: linkon_pkt and lctrl_set are synchronous to clk; lps_in may be
// asynchronous. Thresholds are given in clk cycles.
module lps_supervisor #(
    parameter int RST_THR     = 59,
    parameter int OFF_THR     = 1229,
    parameter int LINKON_DIV  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_in,
    input  logic linkon_pkt,
    input  logic lctrl_set,
    output logic if_enable,
    output logic if_reset,
    output logic if_disabled,
    output logic linkon_out
);
    localparam int CW = $clog2(OFF_THR + 1);

    logic          lps_s;
    logic [CW-1:0] low_cnt;

    lps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (lps_in),
        .q_sync  (lps_s)
    );

    lps_low_timer #(.OFF_THR(OFF_THR), .CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .lps_s   (lps_s),
        .low_cnt (low_cnt)
    );

    lps_ctrl_fsm #(.RST_THR(RST_THR), .OFF_THR(OFF_THR), .CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lps_s       (lps_s),
        .low_cnt     (low_cnt),
        .if_enable   (if_enable),
        .if_reset    (if_reset),
        .if_disabled (if_disabled)
    );

    lps_linkon_gen #(.DIV(LINKON_DIV)) u_linkon (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_off   (if_disabled),
        .linkon_pkt (linkon_pkt),
        .lctrl_set  (lctrl_set),
        .linkon_out (linkon_out)
    );
endmodule

// File: tb/lps_supervisor_bench.sv
module lps_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int LOW_LEN [NV] = '{1, 30, 58, 59, 60, 600, 1228, 1229};
    localparam int EXP_PUL [NV] = '{0, 0, 0, 1, 1, 1, 1, 0};
    localparam bit EXP_OFF [NV] = '{0, 0, 0, 0, 0, 0, 0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lps_in = 1'b0;
    logic linkon_pkt = 1'b0;
    logic lctrl_set = 1'b0;
    logic if_enable, if_reset, if_disabled, linkon_out;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lps_supervisor u_lps_supervisor (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .linkon_pkt(linkon_pkt),
        .lctrl_set(lctrl_set), .if_enable(if_enable), .if_reset(if_reset),
        .if_disabled(if_disabled), .linkon_out(linkon_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive lps low for len cycles, then high for 12; observe outputs.
    task automatic run_low(input int len, output int pulses, output bit saw_off,
                           output bit en_drop);
        pulses = 0; saw_off = 0; en_drop = 0;
        lps_in = 1'b0;
        for (int i = 0; i < len + 12; i++) begin
            if (i == len) lps_in = 1'b1;
            @(negedge clk);
            if (if_reset) pulses++;
            if (if_disabled) saw_off = 1;
            if (!if_enable) en_drop = 1;
        end
    endtask

    // Count high samples and rising transitions of linkon_out over n cycles.
    task automatic measure_linkon(input int n, output int highs, output int rises);
        logic prev;
        highs = 0; rises = 0; prev = linkon_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (linkon_out) highs++;
            if (linkon_out && !prev) rises++;
            prev = linkon_out;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc == 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int  p, h, r;
        bit  so, ed;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(if_disabled == 1'b1, "R1 if_disabled", if_disabled, 1);
        chk(if_enable == 1'b0, "R1 if_enable", if_enable, 0);
        chk(if_reset == 1'b0, "R1 if_reset", if_reset, 0);
        chk(linkon_out == 1'b0, "R1 linkon_out", linkon_out, 0);

        // R2 synchronizer latency and wake without reset pulse
        lps_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(if_disabled == 1'b1, "R2 still off after e1", if_disabled, 1);
        @(negedge clk);
        chk(if_enable == 1'b1, "R2 enabled after e2", if_enable, 1);
        p = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (if_reset) p++;
        end
        chk(p == 0, "R2 no pulse on wake", p, 0);

        // R7 link-on strobe while enabled is ignored
        linkon_pkt = 1'b1;
        @(negedge clk);
        linkon_pkt = 1'b0;
        measure_linkon(24, h, r);
        chk(h == 0, "R7 linkon idle while enabled", h, 0);

        // R3 R4 R5 low-interval classification table
        for (int v = 0; v < NV; v++) begin
            run_low(LOW_LEN[v], p, so, ed);
            chk(p == EXP_PUL[v], $sformatf("R3/R4 pulses len=%0d", LOW_LEN[v]), p, EXP_PUL[v]);
            chk(so == EXP_OFF[v], $sformatf("R5 off len=%0d", LOW_LEN[v]), so, EXP_OFF[v]);
            if (!EXP_OFF[v])
                chk(ed == 1'b0, $sformatf("R4 enable held len=%0d", LOW_LEN[v]), ed, 0);
            chk(if_enable == 1'b1, $sformatf("R5 enabled after return len=%0d", LOW_LEN[v]), if_enable, 1);
        end

        // R5 long interval: observe disabled state while low
        lps_in = 1'b0;
        repeat (1300) @(negedge clk);
        chk(if_disabled == 1'b1 && if_enable == 1'b0, "R5 off while low", if_disabled, 1);

        // R6 wake-up clock started while disabled
        linkon_pkt = 1'b1;
        @(negedge clk);
        linkon_pkt = 1'b0;
        repeat (16) @(negedge clk);
        measure_linkon(64, h, r);
        chk(h == 32, "R6 linkon high samples", h, 32);
        chk(r == 8, "R6 linkon periods", r, 8);

        // R9 keeps running after re-enable
        lps_in = 1'b1;
        repeat (6) @(negedge clk);
        chk(if_enable == 1'b1, "R9 re-enabled", if_enable, 1);
        measure_linkon(64, h, r);
        chk(h == 32, "R9 linkon still running", h, 32);

        // R8 link-control bit stops the clock
        lctrl_set = 1'b1;
        @(negedge clk);
        lctrl_set = 1'b0;
        chk(linkon_out == 1'b0, "R8 stopped next cycle", linkon_out, 0);
        measure_linkon(40, h, r);
        chk(h == 0, "R8 held low", h, 0);

        // R8 priority over a simultaneous strobe while disabled
        lps_in = 1'b0;
        repeat (1300) @(negedge clk);
        linkon_pkt = 1'b1;
        lctrl_set = 1'b1;
        @(negedge clk);
        linkon_pkt = 1'b0;
        lctrl_set = 1'b0;
        measure_linkon(40, h, r);
        chk(h == 0, "R8 clear wins over strobe", h, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule